// File: doc/BRIEF.md
# Debug Command Sequencer with Handshake

This block is the command front end of an on-chip debug port. A host delivers bytes one at a time over a simple shift interface. While the sequencer is idle, each delivered byte is taken as an 8-bit command opcode. Some opcodes carry operands. For those, the sequencer gathers the next four bytes into two 16-bit holding registers, one for an address and one for a count or write value. When the command is complete, the sequencer publishes a 4-bit command code to the firmware. It then raises a one-cycle redirect request that carries a fixed service-routine vector.

After the redirect, the work is done by a firmware service routine, which is modelled here by two strobes. The routine moves data through a transfer-complete flag. The routine sets this flag when it has loaded a byte, and the shift logic clears it when a byte shift finishes. The routine reports that it has finished by setting an operation-done bit. The sequencer recognises that bit, clears it and goes back to waiting for an opcode. The host can also abandon a half-received command with an abort input.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, `ready` is 1, `busy` is 0, `jump_req` is 0, and `cmd_code`, `addr_hold`, `data_hold`, `xfer_flag` and `op_done` are all 0.
- R2: Opcode 0x21 accepted while idle takes no operands. On the next cycle `jump_req` is 1, `cmd_code` is 4'b0001 and `ready` is 0.
- R3: Opcodes 0x22, 0x23 and 0x24 raise `busy` on the cycle after the opcode and accept exactly four further bytes. Those bytes are, in order, address bits 7:0, address bits 15:8, data bits 7:0 and data bits 15:8. On the cycle after the fourth byte, `addr_hold` and `data_hold` hold the assembled values, `cmd_code` equals the opcode minus 0x20 (0010, 0011 or 0100), `jump_req` is 1 and `busy` is 0.
- R4: Every other opcode value, 0x20 included, is a no-operation. `ready` stays 1, `jump_req` stays 0, and `cmd_code`, `addr_hold` and `data_hold` keep their previous values.
- R5: `jump_req` is high for exactly one cycle per command. While it is high, `jump_vec` equals the VECTOR parameter (default 0x8010). At all other times `jump_vec` is 0.
- R6: After a redirect, `ready` stays 0 and host bytes are ignored (no jump, operands unchanged) until `op_done` has been seen.
- R7: `fw_done_set` makes `op_done` 1 on the next cycle. The sequencer clears `op_done` one cycle after it reads 1, and on that same edge `ready` returns to 1. A set in the same cycle as the clear wins.
- R8: `fw_xfer_set` makes `xfer_flag` 1 and `shift_done` makes it 0. When both come in the same cycle, the flag ends at 1.
- R9: `abort` during operand collection returns the sequencer to idle on the next cycle, with `addr_hold` and `data_hold` cleared to 0. A byte presented in the same cycle as `abort` is discarded.
- R10: `abort` while idle or while waiting for completion has no effect on `ready`, `jump_req`, `cmd_code` or the holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A host byte is present this cycle |
| rx_byte | input | 8 | Host byte (opcode or operand) |
| abort | input | 1 | Cancel operand collection |
| shift_done | input | 1 | A byte shift cycle finished; clears the transfer flag |
| fw_xfer_set | input | 1 | Firmware strobe: output byte loaded |
| fw_done_set | input | 1 | Firmware strobe: task finished |
| ready | output | 1 | Idle and accepting an opcode |
| busy | output | 1 | Collecting operands, more input needed |
| cmd_code | output | 4 | Command code published to firmware |
| addr_hold | output | 16 | Collected address operand |
| data_hold | output | 16 | Collected count or write-data operand |
| jump_req | output | 1 | One-cycle redirect request |
| jump_vec | output | 16 | Redirect target, valid with jump_req |
| xfer_flag | output | 1 | Transfer-complete flag |
| op_done | output | 1 | Operation-done bit |

## Verification
Two pairs of events can land on the same clock edge. A firmware set can meet the clear of its own flag, and an abort can meet the arrival of a host byte. The bench forces each pair: it pulses `fw_xfer_set` together with `shift_done`, and `fw_done_set` on the cycle in which `op_done` is being cleared. It then checks that the flag reads 1 afterwards. It also presents an operand byte together with `abort` and checks that both holding registers read zero and that no redirect follows. The abort-and-byte case is provoked both before any operand has arrived and after two operands have arrived.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EXEC    = 2'd2
  } seq_state_t;

  localparam logic [7:0] OPC_REGMAP = 8'h21;
  localparam logic [7:0] OPC_RDMEM  = 8'h22;
  localparam logic [7:0] OPC_RDSTK  = 8'h23;
  localparam logic [7:0] OPC_WRREG  = 8'h24;
  localparam logic [7:0] OPC_BASE   = 8'h20;

  // Opcodes that need an address and a data/count operand.
  function automatic logic needs_operands(input logic [7:0] op);
    return (op == OPC_RDMEM) || (op == OPC_RDSTK) || (op == OPC_WRREG);
  endfunction

  // Opcodes that redirect at once, with no operands.
  function automatic logic runs_now(input logic [7:0] op);
    return op == OPC_REGMAP;
  endfunction

  // Command code handed to firmware.
  function automatic logic [3:0] cmd_of(input logic [7:0] op);
    logic [7:0] diff;
    diff = op - OPC_BASE;
    return diff[3:0];
  endfunction

endpackage

// File: rtl/dbg_opnd_collect.sv
module dbg_opnd_collect #(
  parameter int OPND_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  logic [7:0]              byte_in,
  output logic [8*OPND_BYTES-1:0] opnd,
  output logic                    last_take
);
  localparam int CW = (OPND_BYTES > 1) ? $clog2(OPND_BYTES) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(OPND_BYTES - 1);

  logic [CW-1:0] cnt;

  assign last_take = take && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || last_take) cnt <= '0;
    else if (take)                    cnt <= cnt + 1'b1;
  end

  // One lane per operand byte; lane 0 is the first byte after the opcode.
  for (genvar g = 0; g < OPND_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                   opnd[8*g +: 8] <= 8'h00;
      else if (take && (cnt == CW'(g)))      opnd[8*g +: 8] <= byte_in;
    end
  end
endmodule

// File: rtl/dbg_hs_flags.sv
module dbg_hs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fw_xfer_set,
  input  logic shift_done,
  input  logic fw_done_set,
  input  logic done_ack,
  output logic xfer_flag,
  output logic op_done
);
  // Firmware sets win over engine clears in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)           xfer_flag <= 1'b0;
    else if (fw_xfer_set) xfer_flag <= 1'b1;
    else if (shift_done)  xfer_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           op_done <= 1'b0;
    else if (fw_done_set) op_done <= 1'b1;
    else if (done_ack)    op_done <= 1'b0;
  end
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
#(
  parameter int          FIELD_W = 16,
  parameter logic [15:0] VECTOR  = 16'h8010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               abort,
  input  logic               shift_done,
  input  logic               fw_xfer_set,
  input  logic               fw_done_set,
  output logic               ready,
  output logic               busy,
  output logic [3:0]         cmd_code,
  output logic [FIELD_W-1:0] addr_hold,
  output logic [FIELD_W-1:0] data_hold,
  output logic               jump_req,
  output logic [15:0]        jump_vec,
  output logic               xfer_flag,
  output logic               op_done
);
  localparam int OPND_BYTES = 2 * FIELD_W / 8;

  seq_state_t st;
  logic [3:0] pend_cmd;
  logic [8*OPND_BYTES-1:0] opnd;

  // Named internal events, also observed by the checker.
  logic accept, start_collect, start_now, take, cancel, last_take, fire, done_seen;

  assign ready         = (st == ST_IDLE);
  assign busy          = (st == ST_COLLECT);
  assign accept        = ready && rx_valid && !abort;
  assign start_collect = accept && needs_operands(rx_byte);
  assign start_now     = accept && runs_now(rx_byte);
  assign take          = busy && rx_valid && !abort;
  assign cancel        = busy && abort;
  assign fire          = start_now || last_take;
  assign done_seen     = op_done;

  dbg_opnd_collect #(.OPND_BYTES(OPND_BYTES)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_collect || cancel),
    .take      (take),
    .byte_in   (rx_byte),
    .opnd      (opnd),
    .last_take (last_take)
  );

  dbg_hs_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fw_xfer_set (fw_xfer_set),
    .shift_done  (shift_done),
    .fw_done_set (fw_done_set),
    .done_ack    (done_seen),
    .xfer_flag   (xfer_flag),
    .op_done     (op_done)
  );

  assign addr_hold = opnd[FIELD_W-1:0];
  assign data_hold = opnd[2*FIELD_W-1:FIELD_W];
  assign jump_vec  = jump_req ? VECTOR : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pend_cmd <= 4'h0;
      cmd_code <= 4'h0;
      jump_req <= 1'b0;
    end else begin
      jump_req <= fire;
      if (start_collect) pend_cmd <= cmd_of(rx_byte);
      if (start_now)     cmd_code <= cmd_of(rx_byte);
      else if (last_take) cmd_code <= pend_cmd;
      unique case (st)
        ST_IDLE: begin
          if (start_collect)  st <= ST_COLLECT;
          else if (start_now) st <= ST_EXEC;
        end
        ST_COLLECT: begin
          if (cancel)         st <= ST_IDLE;
          else if (last_take) st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (done_seen)      st <= ST_IDLE;
        end
        default:              st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk #(
  parameter int          FIELD_W = 16,
  parameter logic [15:0] VECTOR  = 16'h8010
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_valid,
  input logic [7:0]         rx_byte,
  input logic               abort,
  input logic               shift_done,
  input logic               fw_xfer_set,
  input logic               fw_done_set,
  input logic               ready,
  input logic               busy,
  input logic [3:0]         cmd_code,
  input logic [FIELD_W-1:0] addr_hold,
  input logic [FIELD_W-1:0] data_hold,
  input logic               jump_req,
  input logic [15:0]        jump_vec,
  input logic               xfer_flag,
  input logic               op_done,
  input logic               last_take
);
  a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rx_valid && !abort && rx_byte == 8'h21) |=> (jump_req && cmd_code == 4'h1 && !ready));

  a_r3_jump_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (jump_req && !busy));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> !jump_req);

  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> (jump_vec == VECTOR));

  a_r6_exec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !busy && !op_done) |=> !ready);

  a_r7_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !fw_done_set) |=> !op_done);

  a_r8_xfer_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && !fw_xfer_set) |=> !xfer_flag);

  a_r8_xfer_set: assert property (@(posedge clk) disable iff (!rst_n)
    fw_xfer_set |=> xfer_flag);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (ready && addr_hold == '0 && data_hold == '0 && !jump_req));

  a_r10_abort_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !busy && abort && !op_done) |=> ($stable(cmd_code) && $stable(addr_hold) && !ready));
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk #(.FIELD_W(FIELD_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .abort(abort),
  .shift_done(shift_done), .fw_xfer_set(fw_xfer_set), .fw_done_set(fw_done_set),
  .ready(ready), .busy(busy), .cmd_code(cmd_code), .addr_hold(addr_hold),
  .data_hold(data_hold), .jump_req(jump_req), .jump_vec(jump_vec),
  .xfer_flag(xfer_flag), .op_done(op_done), .last_take(last_take)
);

// File: tb/sim_dbg_cmd_seq.sv
`timescale 1ns/1ps
module sim_dbg_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic abort = 1'b0, shift_done = 1'b0, fw_xfer_set = 1'b0, fw_done_set = 1'b0;
  logic ready, busy, jump_req, xfer_flag, op_done;
  logic [3:0] cmd_code;
  logic [15:0] addr_hold, data_hold, jump_vec;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [3:0]  exp_cmd = 4'h0;
  logic [15:0] exp_addr = 16'h0, exp_data = 16'h0;

  always #5 clk = ~clk;

  dbg_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .abort(abort),
    .shift_done(shift_done), .fw_xfer_set(fw_xfer_set), .fw_done_set(fw_done_set),
    .ready(ready), .busy(busy), .cmd_code(cmd_code), .addr_hold(addr_hold),
    .data_hold(data_hold), .jump_req(jump_req), .jump_vec(jump_vec),
    .xfer_flag(xfer_flag), .op_done(op_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit ab);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; abort = ab;
    @(negedge clk); rx_valid = 1'b0; abort = 1'b0;
  endtask

  // Outputs that must hold when nothing is pending.
  task automatic chk_quiet(input string tag);
    chk(ready === 1'b1, {tag, " ready"}, ready, 1);
    chk(jump_req === 1'b0 && jump_vec === 16'h0, {tag, " nojump"}, {jump_req, jump_vec}, 0);
    chk(cmd_code === exp_cmd, {tag, " cmd"}, cmd_code, exp_cmd);
    chk(addr_hold === exp_addr && data_hold === exp_data, {tag, " hold"},
        {addr_hold, data_hold}, {exp_addr, exp_data});
  endtask

  task automatic finish_task(input string tag);
    @(negedge clk); fw_done_set = 1'b1;
    @(negedge clk); fw_done_set = 1'b0;
    chk(op_done === 1'b1 && ready === 1'b0, {tag, " R7 done seen"}, {op_done, ready}, 2'b10);
    @(negedge clk);
    chk(op_done === 1'b0 && ready === 1'b1, {tag, " R7 done cleared"}, {op_done, ready}, 2'b01);
  endtask

  task automatic chk_jump(input string tag);
    chk(jump_req === 1'b1 && jump_vec === 16'h8010, {tag, " R5 jump"}, {jump_req, jump_vec}, {1'b1, 16'h8010});
    chk(cmd_code === exp_cmd, {tag, " cmd"}, cmd_code, exp_cmd);
    chk(ready === 1'b0 && busy === 1'b0, {tag, " exec"}, {ready, busy}, 0);
    @(negedge clk);
    chk(jump_req === 1'b0 && jump_vec === 16'h0, {tag, " R5 one cycle"}, {jump_req, jump_vec}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(ready === 1 && busy === 0 && jump_req === 0 && cmd_code === 0, "R1 control", {ready, busy, jump_req, cmd_code}, 7'b1000000);
    chk(addr_hold === 0 && data_hold === 0 && xfer_flag === 0 && op_done === 0, "R1 data", {addr_hold, data_hold}, 0);

    // Sweep over every opcode value.
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o, a0, a1, d0, d1;
      o = 8'(op); a0 = o ^ 8'h5A; a1 = ~o; d0 = o + 8'd1; d1 = 8'(op * 3);
      if (o == 8'h21) begin
        send(o, 1'b0);
        exp_cmd = 4'h1;
        chk_jump("R2 regmap");
        send(8'h22, 1'b0); // R6 ignored while executing
        chk(jump_req === 0 && ready === 0 && busy === 0, "R6 byte ignored", {jump_req, ready, busy}, 0);
        finish_task("R2");
      end else if (o >= 8'h22 && o <= 8'h24) begin
        send(o, 1'b0);
        chk(busy === 1 && ready === 0, "R3 busy", {busy, ready}, 2'b10);
        send(a0, 1'b0); send(a1, 1'b0); send(d0, 1'b0);
        chk(busy === 1 && jump_req === 0, "R3 still busy", {busy, jump_req}, 2'b10);
        @(negedge clk); rx_valid = 1'b1; rx_byte = d1;
        @(negedge clk); rx_valid = 1'b0;
        exp_cmd = 4'(o - 8'h20); exp_addr = {a1, a0}; exp_data = {d1, d0};
        chk(addr_hold === exp_addr && data_hold === exp_data, "R3 operands",
            {addr_hold, data_hold}, {exp_addr, exp_data});
        chk_jump("R3 collected");
        send(8'h21, 1'b1); // R10 abort plus byte during exec
        chk(ready === 0 && jump_req === 0 && cmd_code === exp_cmd && addr_hold === exp_addr,
            "R10 abort in exec", {ready, jump_req, cmd_code}, {2'b00, exp_cmd});
        finish_task("R3");
      end else begin
        send(o, 1'b0);
        chk_quiet("R4 nop");
      end
    end

    // R9 abort after two operand bytes, with a byte in the same cycle.
    send(8'h24, 1'b0); send(8'h11, 1'b0); send(8'h22, 1'b0);
    send(8'h33, 1'b1);
    exp_addr = 16'h0; exp_data = 16'h0;
    chk(addr_hold === 0 && data_hold === 0 && ready === 1 && busy === 0, "R9 abort mid",
        {addr_hold, data_hold, ready, busy}, 34'h1 << 1);
    repeat (2) @(negedge clk);
    chk(jump_req === 0 && ready === 1, "R9 no jump after abort", {jump_req, ready}, 2'b01);
    // R9 abort before any operand, with a byte present.
    send(8'h23, 1'b0); send(8'hAB, 1'b1);
    chk(ready === 1 && addr_hold === 0, "R9 abort first", {ready, addr_hold}, 17'h10000);
    // R10 abort while idle, including with an opcode present.
    send(8'h21, 1'b1);
    chk_quiet("R10 abort idle");

    // R8 transfer flag.
    @(negedge clk); fw_xfer_set = 1; @(negedge clk); fw_xfer_set = 0;
    chk(xfer_flag === 1, "R8 set", xfer_flag, 1);
    @(negedge clk); shift_done = 1; @(negedge clk); shift_done = 0;
    chk(xfer_flag === 0, "R8 clear", xfer_flag, 0);
    @(negedge clk); shift_done = 1; fw_xfer_set = 1; @(negedge clk); shift_done = 0; fw_xfer_set = 0;
    chk(xfer_flag === 1, "R8 collide", xfer_flag, 1);
    @(negedge clk); shift_done = 1; fw_xfer_set = 1; @(negedge clk); shift_done = 0; fw_xfer_set = 0;
    chk(xfer_flag === 1, "R8 collide while set", xfer_flag, 1);

    // R7 set while the clear is happening: the set wins.
    @(negedge clk); fw_done_set = 1; @(negedge clk);
    chk(op_done === 1, "R7 set", op_done, 1);
    @(negedge clk); fw_done_set = 0;
    chk(op_done === 1, "R7 collide", op_done, 1);
    @(negedge clk);
    chk(op_done === 0, "R7 cleared after", op_done, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule